// File: doc/BRIEF.md
# Descriptor Ring Writeback Controller

This block returns completed descriptors from an on-chip descriptor cache to a circular ring in host memory. On a writeback request it takes the number of used descriptors held in the cache, the current ring head and the ring size. It then chooses how many descriptors to write. The count stops at the end of the ring and, when the request carries an alignment mask, is rounded down to that alignment. After a programmable delay the block raises a single DMA write request. The request address is the ring base plus the head times the 16-byte descriptor size, and it carries a byte length.

Only one writeback can be outstanding. A request that arrives while one is in progress is merged: if its mask is smaller, the block keeps that smaller mask and marks that a follow-up writeback is owed. When the DMA engine reports completion, the block releases the written entries from the cache, reports the advanced and wrapped head, and, in the transmit variant, raises an interrupt pulse. If a follow-up is owed, the block runs a new writeback with the recorded mask without software involvement. A drain input holds a pending DMA back without losing it.

Top module: `ring_wb_ctrl`

## Requirements
- R1: At most one writeback is outstanding. A `wb_req` that arrives while `idle` is low never starts a second DMA. If its mask is numerically smaller than the recorded mask, it replaces the recorded mask and marks a follow-up as owed; otherwise it has no effect.
- R2: When used_count + ring_head is greater than or equal to the ring size, the count is ring size − ring_head, and a follow-up is owed.
- R3: When the count is not clipped by R2, it is used_count & ~mask.
- R4: When the resulting count is zero, no DMA request is raised and the block returns to idle.
- R5: `dma_req` is a one-cycle pulse. For a request accepted at clock edge e, it is high in the cycle after edge e+D+1, where D is `wb_delay`. For a follow-up, the evaluation edge is the second edge after the completion-report cycle, and the same delay then applies.
- R6: While `drain` is high, no DMA request is raised. If the delay expires while drain is high, the delay restarts.
- R7: `dma_addr` = ring_base + head × 16 and `dma_bytes` = count × 16, both taken at the evaluation edge.
- R8: Used entries are released only after completion. For one cycle after the edge that samples `dma_done`, `pop_valid` is high with `pop_count` equal to the issued count. `pop_valid` is never high before `dma_done`.
- R9: In that same cycle `head_upd` is high. `head_new` = head + count, minus the ring size when the sum is at least the ring size, so it always lies within the ring.
- R10: The transmit variant (IS_TX = 1) pulses `irq` together with every `head_upd`. The receive variant never raises `irq`.
- R11: After completion with a follow-up owed, a new writeback is evaluated with the recorded mask against the updated used_count and ring_head.
- R12: `idle` is high exactly when no writeback is waiting, issued, in flight or owed.
- R13: The ring size in descriptors is `ring_bytes` shifted right by 4. The low four bits of `ring_bytes` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_req | input | 1 | Writeback request pulse |
| wb_mask | input | IDX_W | Alignment mask carried by the request |
| used_count | input | IDX_W | Used descriptors held in the cache |
| ring_head | input | IDX_W | Current ring head index |
| ring_bytes | input | IDX_W+DESC_SHIFT | Ring length in bytes |
| ring_base | input | ADDR_W | Ring base address |
| wb_delay | input | DELAY_W | Cycles to wait before issuing |
| drain | input | 1 | Hold back DMA issue |
| dma_done | input | 1 | DMA write completion pulse |
| dma_req | output | 1 | DMA write request pulse |
| dma_addr | output | ADDR_W | DMA write address |
| dma_bytes | output | IDX_W+DESC_SHIFT | DMA write length in bytes |
| pop_valid | output | 1 | Release written entries from cache |
| pop_count | output | IDX_W | Number of entries to release |
| head_upd | output | 1 | New head valid |
| head_new | output | IDX_W | Advanced, wrapped head |
| irq | output | 1 | Writeback-done interrupt pulse (transmit only) |
| idle | output | 1 | Nothing outstanding or owed |

## Verification
The bench counts falling edges from the cycle in which it drives a request. It expects `dma_req` at exactly D+2 falling edges for a fresh request and at D+3 falling edges, counted from the completion-report cycle, for a follow-up. It drives `dma_done` at least one cycle after the request pulse. It expects the release, head and interrupt outputs on the very next falling edge and checks that none of them appears earlier. For a zero count and after drain release, it watches a window of D+3 cycles rather than a single edge.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ISSUE,
        ST_BUSY,
        ST_DONE,
        ST_RETRY
    } wb_state_e;

    typedef struct packed {
        logic clipped;
        logic empty;
    } size_flags_t;

    localparam int DESC_SHIFT_DEF = 4;

endpackage

// File: rtl/wbc_sizer.sv
module wbc_sizer
    import wbc_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] used,
    input  logic [IDX_W-1:0] head,
    input  logic [IDX_W-1:0] ring_len,
    input  logic [IDX_W-1:0] mask,
    output logic [IDX_W-1:0] count,
    output size_flags_t      flags
);
    logic [IDX_W:0] reach;

    always_comb begin
        reach = {1'b0, used} + {1'b0, head};
        flags.clipped = (reach >= {1'b0, ring_len});
        if (flags.clipped) begin
            count = ring_len - head;
        end else begin
            count = used & ~mask;
        end
        flags.empty = (count == '0);
    end
endmodule

// File: rtl/wbc_delay.sv
module wbc_delay #(
    parameter int DELAY_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               hold,
    input  logic [DELAY_W-1:0] limit,
    output logic               expire
);
    logic               running;
    logic [DELAY_W-1:0] ticks;
    logic               at_limit;

    assign at_limit = running && (ticks >= limit);
    assign expire   = at_limit && !hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            ticks   <= '0;
        end else if (start) begin
            running <= 1'b1;
            ticks   <= '0;
        end else if (running) begin
            if (at_limit) begin
                if (hold) begin
                    ticks <= '0;
                end else begin
                    running <= 1'b0;
                end
            end else begin
                ticks <= ticks + 1'b1;
            end
        end
    end

    AST_NO_EXPIRE_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (running && hold) |=> !(expire && $past(hold) && $past(at_limit))) // R6
        else $error("expire during hold");
endmodule

// File: rtl/wbc_advance.sv
module wbc_advance #(
    parameter int IDX_W      = 8,
    parameter int ADDR_W     = 32,
    parameter int DESC_SHIFT = 4
) (
    input  logic [ADDR_W-1:0]           base,
    input  logic [IDX_W-1:0]            head,
    input  logic [IDX_W-1:0]            count,
    input  logic [IDX_W-1:0]            ring_len,
    output logic [ADDR_W-1:0]           addr,
    output logic [IDX_W+DESC_SHIFT-1:0] bytes,
    output logic [IDX_W-1:0]            head_next
);
    logic [IDX_W:0] sum;

    always_comb begin
        addr  = base + (ADDR_W'(head) << DESC_SHIFT);
        bytes = {count, {DESC_SHIFT{1'b0}}};
        sum   = {1'b0, head} + {1'b0, count};
        if (sum >= {1'b0, ring_len}) begin
            sum = sum - {1'b0, ring_len};
        end
        head_next = sum[IDX_W-1:0];
    end
endmodule

// File: rtl/ring_wb_ctrl.sv
module ring_wb_ctrl
    import wbc_pkg::*;
#(
    parameter int IDX_W      = 8,
    parameter int ADDR_W     = 32,
    parameter int DELAY_W    = 8,
    parameter int DESC_SHIFT = DESC_SHIFT_DEF,
    parameter bit IS_TX      = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wb_req,
    input  logic [IDX_W-1:0]            wb_mask,
    input  logic [IDX_W-1:0]            used_count,
    input  logic [IDX_W-1:0]            ring_head,
    input  logic [IDX_W+DESC_SHIFT-1:0] ring_bytes,
    input  logic [ADDR_W-1:0]           ring_base,
    input  logic [DELAY_W-1:0]          wb_delay,
    input  logic                        drain,
    input  logic                        dma_done,
    output logic                        dma_req,
    output logic [ADDR_W-1:0]           dma_addr,
    output logic [IDX_W+DESC_SHIFT-1:0] dma_bytes,
    output logic                        pop_valid,
    output logic [IDX_W-1:0]            pop_count,
    output logic                        head_upd,
    output logic [IDX_W-1:0]            head_new,
    output logic                        irq,
    output logic                        idle
);
    localparam int BYTE_W = IDX_W + DESC_SHIFT;

    wb_state_e        state;
    logic [IDX_W-1:0] mask_r;
    logic             owed_r;
    logic [IDX_W-1:0] cnt_r;
    logic [IDX_W-1:0] head_r;

    logic [IDX_W-1:0] ring_len;
    logic [IDX_W-1:0] eval_mask;
    logic [IDX_W-1:0] sz_count;
    size_flags_t      sz_flags;
    logic             evaluate;
    logic             merge_hit;
    logic             owed_nx;
    logic             dly_expire;
    logic [BYTE_W-1:0] adv_bytes;

    assign ring_len  = IDX_W'(ring_bytes >> DESC_SHIFT);
    assign merge_hit = wb_req && (wb_mask < mask_r);
    assign eval_mask = (state == ST_RETRY) ? (merge_hit ? wb_mask : mask_r) : wb_mask;
    assign evaluate  = ((state == ST_IDLE) && wb_req) || (state == ST_RETRY);
    assign owed_nx   = owed_r || merge_hit;

    wbc_sizer #(.IDX_W(IDX_W)) i_sizer (
        .used     (used_count),
        .head     (ring_head),
        .ring_len (ring_len),
        .mask     (eval_mask),
        .count    (sz_count),
        .flags    (sz_flags)
    );

    wbc_delay #(.DELAY_W(DELAY_W)) i_delay (
        .clk    (clk),
        .rst    (rst),
        .start  (evaluate && !sz_flags.empty),
        .hold   (drain),
        .limit  (wb_delay),
        .expire (dly_expire)
    );

    wbc_advance #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .DESC_SHIFT(DESC_SHIFT)) i_advance (
        .base      (ring_base),
        .head      (head_r),
        .count     (cnt_r),
        .ring_len  (ring_len),
        .addr      (dma_addr),
        .bytes     (adv_bytes),
        .head_next (head_new)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            mask_r <= '0;
            owed_r <= 1'b0;
            cnt_r  <= '0;
            head_r <= '0;
        end else begin
            if (evaluate) begin
                mask_r <= eval_mask;
                owed_r <= sz_flags.clipped;
                cnt_r  <= sz_count;
                head_r <= ring_head;
                state  <= sz_flags.empty ? ST_IDLE : ST_WAIT;
            end else begin
                if (state != ST_IDLE && merge_hit) begin
                    mask_r <= wb_mask;
                    owed_r <= 1'b1;
                end
                unique case (state)
                    ST_WAIT:  if (dly_expire) state <= ST_ISSUE;
                    ST_ISSUE: state <= ST_BUSY;
                    ST_BUSY:  if (dma_done) state <= ST_DONE;
                    ST_DONE:  state <= owed_nx ? ST_RETRY : ST_IDLE;
                    default:  state <= state;
                endcase
            end
        end
    end

    assign dma_req   = (state == ST_ISSUE);
    assign dma_bytes = adv_bytes;
    assign pop_valid = (state == ST_DONE);
    assign pop_count = cnt_r;
    assign head_upd  = (state == ST_DONE);
    assign idle      = (state == ST_IDLE);

    generate
        if (IS_TX) begin : g_tx_irq
            assign irq = (state == ST_DONE);
        end else begin : g_rx_irq
            assign irq = 1'b0;
        end
    endgenerate

    AST_SINGLE_ISSUE: assert property (@(posedge clk) disable iff (rst)
        dma_req |=> !dma_req) // R1
        else $error("back-to-back dma_req");
    AST_NONZERO_ISSUE: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> (dma_bytes != '0)) // R4
        else $error("empty DMA issued");
    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_req) |-> !$past(drain)) // R6
        else $error("issue while draining");
    AST_POP_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        pop_valid |-> $past(dma_done)) // R8
        else $error("pop before completion");
    AST_HEAD_IN_RING: assert property (@(posedge clk) disable iff (rst)
        head_upd |-> (head_new < ring_len)) // R9
        else $error("head out of ring");
    AST_IRQ_WITH_HEAD: assert property (@(posedge clk) disable iff (rst)
        irq |-> head_upd) // R10
        else $error("irq without completion");
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        idle |-> (!dma_req && !pop_valid && !head_upd)) // R12
        else $error("activity while idle");
endmodule

// File: tb/test_ring_wb_ctrl.sv
module test_ring_wb_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W  = 8;
    localparam int ADDR_W = 32;
    localparam int DLY_W  = 8;
    localparam int SHIFT  = 4;
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wb_req = 1'b0;
    logic [IDX_W-1:0] wb_mask = '0;
    logic [IDX_W-1:0] used_count;
    logic [IDX_W-1:0] ring_head;
    logic [IDX_W+SHIFT-1:0] ring_bytes;
    logic [ADDR_W-1:0] ring_base = 32'h8000_1000;
    logic [DLY_W-1:0] wb_delay = '0;
    logic drain = 1'b0;
    logic dma_done = 1'b0;

    logic dma_req, pop_valid, head_upd, irq, idle;
    logic [ADDR_W-1:0] dma_addr;
    logic [IDX_W+SHIFT-1:0] dma_bytes;
    logic [IDX_W-1:0] pop_count, head_new;
    logic rx_req, rx_pop, rx_upd, rx_irq, rx_idle;
    logic [ADDR_W-1:0] rx_addr;
    logic [IDX_W+SHIFT-1:0] rx_bytes;
    logic [IDX_W-1:0] rx_pcnt, rx_head;

    int len = 16;
    int head_m = 0;
    int used_m = 0;
    int total = 0;
    int bad = 0;
    int cyc = 0;

    assign used_count = IDX_W'(used_m);
    assign ring_head  = IDX_W'(head_m);

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_wb_ctrl i_ring_wb_ctrl (
        .clk(clk), .rst(rst), .wb_req(wb_req), .wb_mask(wb_mask),
        .used_count(used_count), .ring_head(ring_head), .ring_bytes(ring_bytes),
        .ring_base(ring_base), .wb_delay(wb_delay), .drain(drain), .dma_done(dma_done),
        .dma_req(dma_req), .dma_addr(dma_addr), .dma_bytes(dma_bytes),
        .pop_valid(pop_valid), .pop_count(pop_count), .head_upd(head_upd),
        .head_new(head_new), .irq(irq), .idle(idle)
    );

    ring_wb_ctrl #(.IS_TX(1'b0)) i_ring_wb_ctrl_rx (
        .clk(clk), .rst(rst), .wb_req(wb_req), .wb_mask(wb_mask),
        .used_count(used_count), .ring_head(ring_head), .ring_bytes(ring_bytes),
        .ring_base(ring_base), .wb_delay(wb_delay), .drain(drain), .dma_done(dma_done),
        .dma_req(rx_req), .dma_addr(rx_addr), .dma_bytes(rx_bytes),
        .pop_valid(rx_pop), .pop_count(rx_pcnt), .head_upd(rx_upd),
        .head_new(rx_head), .irq(rx_irq), .idle(rx_idle)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= WATCHDOG) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void plan(input int used, input int head, input int rlen,
                                 input int mask, output int cnt, output bit more);
        if (used + head >= rlen) begin
            cnt  = rlen - head;
            more = 1'b1;
        end else begin
            cnt  = used & ~mask;
            more = 1'b0;
        end
    endfunction

    task automatic set_len(input int l, input int junk);
        len = l;
        ring_bytes = (IDX_W+SHIFT)'(l * 16 + junk); // R13: low bits ignored
    endtask

    task automatic run_txn(input int mask, input int dly, input bit extra, input int xmask);
        int m;
        bit first;
        int cnt;
        bit more;
        int n;
        int exp_n;
        int exp_head;
        bit seen;
        m = mask;
        first = 1'b1;
        wb_delay = DLY_W'(dly);
        @(negedge clk);
        wb_req = 1'b1;
        wb_mask = IDX_W'(mask);
        @(negedge clk);
        wb_req = 1'b0;
        n = 1;
        forever begin
            plan(used_m, head_m, len, m, cnt, more);
            if (cnt == 0) begin
                seen = 1'b0;
                for (int i = 0; i < dly + 3; i++) begin
                    if (dma_req) seen = 1'b1;
                    @(negedge clk);
                end
                check(!seen && idle, "R4 zero count issues nothing", seen, 0);
                break;
            end
            while (!dma_req && n < dly + 20) begin
                @(negedge clk);
                n++;
            end
            exp_n = first ? dly + 2 : dly + 3;
            check(dma_req && n == exp_n, first ? "R5 issue delay" : "R11 reissue delay", n, exp_n);
            check(dma_addr == ring_base + 32'(head_m * 16), "R7 address", dma_addr, ring_base + 32'(head_m * 16));
            check(int'(dma_bytes) == cnt * 16, "R2/R3 count via R7 bytes", dma_bytes, cnt * 16);
            @(negedge clk);
            if (extra && first) begin
                wb_req = 1'b1;
                wb_mask = IDX_W'(xmask);
                @(negedge clk);
                wb_req = 1'b0;
                check(!dma_req, "R1 no second issue", dma_req, 0);
                if (xmask < m) begin
                    more = 1'b1;
                    m = xmask;
                end
            end
            check(!pop_valid && !head_upd, "R8 no pop before done", pop_valid, 0);
            dma_done = 1'b1;
            @(negedge clk);
            dma_done = 1'b0;
            exp_head = head_m + cnt;
            if (exp_head >= len) exp_head -= len;
            check(pop_valid && int'(pop_count) == cnt, "R8 pop count", pop_count, cnt);
            check(head_upd && int'(head_new) == exp_head, "R9 head advance", head_new, exp_head);
            check(irq == 1'b1 && rx_irq == 1'b0 && rx_upd == 1'b1, "R10 irq variant", {irq, rx_irq}, 2);
            used_m -= cnt;
            head_m = exp_head;
            if (!more) begin
                @(negedge clk);
                @(negedge clk);
                check(idle && !dma_req, "R12 idle after completion", idle, 1);
                break;
            end
            check(!idle, "R12 busy while follow-up owed", idle, 0);
            first = 1'b0;
            n = 0;
        end
    endtask

    initial begin
        int dummy;
        dummy = $urandom(32'd2024);
        set_len(16, 5);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(idle && !dma_req && !pop_valid && !irq, "reset state R12", idle, 1);

        // R3: 13 & ~7 = 8, R1 merge with mask 0 -> R11 reissue of 5
        head_m = 0; used_m = 13;
        run_txn(7, 2, 1'b1, 0);
        check(used_m == 0 && head_m == 13, "R11 follow-up drained cache", head_m, 13);

        // R1: larger mask during flight ignored
        head_m = 0; used_m = 13;
        run_txn(3, 1, 1'b1, 7);
        check(used_m == 1 && head_m == 12, "R1 larger mask ignored", used_m, 1);

        // R2 clip at ring end, R9 wrap, R11 reissue from 0
        head_m = 12; used_m = 7;
        run_txn(0, 0, 1'b0, 0);
        check(head_m == 3 && used_m == 0, "R2 split at ring end", head_m, 3);

        // R4: 5 & ~7 = 0
        head_m = 2; used_m = 5;
        run_txn(7, 3, 1'b0, 0);
        check(head_m == 2 && used_m == 5, "R4 nothing written", used_m, 5);

        // R13 with another ring size
        set_len(10, 15);
        head_m = 6; used_m = 4;
        run_txn(1, 1, 1'b0, 0);
        check(head_m == 0, "R13 ring size from bytes", head_m, 0);

        // R6 drain
        set_len(16, 0);
        head_m = 0; used_m = 6;
        wb_delay = 2;
        drain = 1'b1;
        @(negedge clk);
        wb_req = 1'b1; wb_mask = '0;
        @(negedge clk);
        wb_req = 1'b0;
        begin
            bit seen;
            int n;
            seen = 1'b0;
            for (int i = 0; i < 12; i++) begin
                if (dma_req) seen = 1'b1;
                @(negedge clk);
            end
            check(!seen && !idle, "R6 held while draining", seen, 0);
            drain = 1'b0;
            n = 0;
            while (!dma_req && n < 10) begin
                @(negedge clk);
                n++;
            end
            check(dma_req && n <= 3, "R6 issue after release", n, 3);
            @(negedge clk);
            dma_done = 1'b1;
            @(negedge clk);
            dma_done = 1'b0;
            check(pop_valid && pop_count == 6 && head_new == 6, "R8 drain completion", pop_count, 6);
            used_m = 0; head_m = 6;
            @(negedge clk);
            @(negedge clk);
        end

        // random mix
        for (int t = 0; t < 60; t++) begin
            int msel;
            int masks [5] = '{0, 1, 3, 7, 15};
            set_len(int'($urandom_range(40, 4)), int'($urandom_range(15, 0)));
            head_m = int'($urandom_range(len - 1, 0));
            used_m = int'($urandom_range(len, 0));
            msel = int'($urandom_range(4, 0));
            run_txn(masks[msel], int'($urandom_range(4, 0)), $urandom_range(1, 0) == 1,
                    masks[$urandom_range(4, 0)]);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule